// File: doc/BRIEF.md
# Dual-Mode Block-Adaptive Symbol Equalizer

This block is a five-tap complex FIR equalizer that runs at one sample per symbol. It sits after timing recovery and reduces the distortion left by filters and cabling. It retunes its own taps with a gradient that is normalized by input energy and averaged over a block. Each accepted symbol adds a normalized gradient term to a per-tap accumulator. The taps move only once a block of qualifying symbols is complete, by the accumulated sum scaled down by a power-of-two step.

Three modes come from two control pins. With `bypass` high, symbols go straight through and nothing adapts; this is the mode used during first acquisition. With `bypass` low and `frame_lock` low, the equalizer adapts blindly with a constant-modulus error. With `frame_lock` high, it adapts only on known reference symbols, which an outside frame tracker marks with `ref_vld` and supplies on `ref_i`/`ref_q`. Any change of mode puts the taps back to a unit center tap and drops the block in progress.

Samples, references and outputs are signed 12-bit values with 10 fraction bits (1.0 = 1024). Taps are signed 18-bit values with 14 fraction bits.

Top module: `blk_eq_adapt`

## Requirements
- R1: After reset, `out_vld` is low and both outputs are zero. After reset and after every mode change, the center tap (index 2) is 1.0 and every other tap is 0, so each output equals the input accepted two samples earlier.
- R2: Each accepted input (`in_vld` high at a clock edge) gives exactly one output, with `out_vld` high two clock edges later. The outputs do not change on any other cycle.
- R3: With `bypass` high, the output is the input accepted two samples earlier, bit-exact for any value, and the taps do not change.
- R4: In blind mode the error is y·(1 − r), where r approximates 1/|y| from a 16-entry table. The table index is floor(|y|²/0.25), clamped to 15 and floored at 1, and entry n holds 2/√n with 11 fraction bits. An output of exactly unit modulus therefore gives zero error and leaves the taps unchanged.
- R5: In blind mode every accepted symbol contributes to the block. For each tap k the contribution is conj(x_k)·e·2^14 / 2^p, where p = floor(log2 of the sum of |x|² over the five taps, in raw units), and p is never below 14. Example: with every input 1536+0j and step shift 2, the first output after the block update is 1356.
- R6: In pilot mode, symbols without `ref_vld` add nothing to the block, and their reference values are ignored.
- R7: In pilot mode the error is y − p. Here p is the reference sampled with `ref_vld` on the input that is now at the center tap (two accepted samples later). Example: with every input 512, reference 1024 and step shift 2, the first output after the update is 672.
- R8: The taps change only after 8 qualifying symbols have been accumulated. The new taps apply from the output that follows the eighth.
- R9: Toggling `bypass` or `frame_lock` restores the R1 taps and clears the partial block, even after the taps have adapted.
- R10: At each update, every tap decreases by its accumulated sum shifted right by 3 + s, where s = `mu_shift`, and a value of 0 is treated as 1. Example: the R7 case with s = 3 gives 592.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input symbol valid |
| in_i | input | 12 | Input symbol, in-phase |
| in_q | input | 12 | Input symbol, quadrature |
| frame_lock | input | 1 | 0: blind adaptation, 1: reference-driven adaptation |
| bypass | input | 1 | Pass symbols through without filtering or adaptation |
| ref_vld | input | 1 | This input symbol is a known reference |
| ref_i | input | 12 | Reference symbol, in-phase |
| ref_q | input | 12 | Reference symbol, quadrature |
| mu_shift | input | 4 | Step size as a power-of-two shift |
| out_vld | output | 1 | Output symbol valid |
| out_i | output | 12 | Equalized symbol, in-phase |
| out_q | output | 12 | Equalized symbol, quadrature |

## Verification
A wrong tap, accumulator or block count stays hidden at the ports until a block closes. It then appears in the very next output as a value that differs from the exact figures worked out for constant inputs. For that reason the bench checks every output before the block boundary for an unchanged passthrough, and the first output after the boundary for the exact adapted value. A wrong mode-change reset or reference gate shows at once as a departure from passthrough, on sequences that would move the taps if the gate leaked.

// File: rtl/blk_eq_adapt.sv
`timescale 1ns/1ps
module blk_eq_adapt #(
  parameter int W     = 12,
  parameter int FRAC  = 10,
  parameter int CW    = 18,
  parameter int CFRAC = 14,
  parameter int NT    = 5,
  parameter int LOG_L = 3,
  parameter int ACCW  = 24,
  parameter int MUW   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic signed [W-1:0] in_i,
  input  logic signed [W-1:0] in_q,
  input  logic                frame_lock,
  input  logic                bypass,
  input  logic                ref_vld,
  input  logic signed [W-1:0] ref_i,
  input  logic signed [W-1:0] ref_q,
  input  logic [MUW-1:0]      mu_shift,
  output logic                out_vld,
  output logic signed [W-1:0] out_i,
  output logic signed [W-1:0] out_q
);
  localparam int CTR    = NT / 2;
  localparam int PW     = W + CW + $clog2(2 * NT) + 1;
  localparam int EW     = W + 2;
  localparam int TW     = W + 14;
  localparam int M2W    = 2 * W + 2;
  localparam int NW     = 2 * W + $clog2(NT) + 1;
  localparam int GW     = W + EW + 1 + CFRAC;
  localparam int RF     = 11;
  localparam int PFLOOR = 2 * FRAC - 6;
  localparam int IDXSH  = 2 * FRAC - 2;
  localparam logic [CW-1:0] ONE = CW'(1) << CFRAC;

  function automatic logic signed [63:0] clip(input logic signed [63:0] v, input int b);
    logic signed [63:0] hi, lo;
    hi = (64'sd1 <<< (b - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic logic [12:0] rtab(input logic [3:0] n);
    case (n)
      4'd1:  return 13'd4096;
      4'd2:  return 13'd2896;
      4'd3:  return 13'd2365;
      4'd4:  return 13'd2048;
      4'd5:  return 13'd1832;
      4'd6:  return 13'd1672;
      4'd7:  return 13'd1548;
      4'd8:  return 13'd1448;
      4'd9:  return 13'd1365;
      4'd10: return 13'd1295;
      4'd11: return 13'd1235;
      4'd12: return 13'd1182;
      4'd13: return 13'd1136;
      4'd14: return 13'd1095;
      4'd15: return 13'd1058;
      default: return 13'd4096;
    endcase
  endfunction

  logic [NT-1:0][W-1:0]   di, dq;
  logic [CTR:0][W-1:0]    dpi, dpq;
  logic [CTR:0]           dp;
  logic                   vld_d;
  logic [NT-1:0][CW-1:0]  ci, cq, cn_i, cn_q, tap_init;
  logic [NT-1:0][ACCW-1:0] ai, aq, an_i, an_q;
  logic [LOG_L-1:0]       cnt;
  logic [1:0]             mode_q;
  logic                   mode_chg, qual, blk_done;

  assign mode_chg = ({bypass, frame_lock} != mode_q);
  assign qual     = vld_d && !bypass && (!frame_lock || dp[CTR]);
  assign blk_done = qual && (cnt == {LOG_L{1'b1}});

  always_comb
    for (int k = 0; k < NT; k++) tap_init[k] = (k == CTR) ? ONE : '0;

  // filter
  logic signed [PW-1:0] fs_i, fs_q;
  logic signed [W-1:0]  y_i, y_q;
  always_comb begin
    fs_i = '0;
    fs_q = '0;
    for (int k = 0; k < NT; k++) begin
      fs_i = fs_i + PW'($signed(ci[k])) * PW'($signed(di[k]))
                  - PW'($signed(cq[k])) * PW'($signed(dq[k]));
      fs_q = fs_q + PW'($signed(ci[k])) * PW'($signed(dq[k]))
                  + PW'($signed(cq[k])) * PW'($signed(di[k]));
    end
  end
  assign y_i = W'(clip(64'(fs_i >>> CFRAC), W));
  assign y_q = W'(clip(64'(fs_q >>> CFRAC), W));

  // error
  logic signed [M2W-1:0] m2;
  logic [M2W-1:0]        idx_raw;
  logic [3:0]            ridx;
  logic signed [TW-1:0]  rs;
  logic signed [EW-1:0]  e_i, e_q, eb_i, eb_q, ep_i, ep_q;
  assign m2      = M2W'(y_i) * M2W'(y_i) + M2W'(y_q) * M2W'(y_q);
  assign idx_raw = $unsigned(m2) >> IDXSH;
  assign ridx    = (idx_raw > M2W'(15)) ? 4'd15 :
                   (idx_raw == '0)      ? 4'd1  : idx_raw[3:0];
  assign rs      = $signed(TW'(rtab(ridx)));
  assign eb_i    = EW'(TW'(y_i) - ((TW'(y_i) * rs) >>> RF));
  assign eb_q    = EW'(TW'(y_q) - ((TW'(y_q) * rs) >>> RF));
  assign ep_i    = EW'(y_i) - EW'($signed(dpi[CTR]));
  assign ep_q    = EW'(y_q) - EW'($signed(dpq[CTR]));
  assign e_i     = frame_lock ? ep_i : eb_i;
  assign e_q     = frame_lock ? ep_q : eb_q;

  // input energy normalizer
  logic signed [NW-1:0] nrm;
  int lead, sh;
  always_comb begin
    nrm = '0;
    for (int k = 0; k < NT; k++)
      nrm = nrm + NW'($signed(di[k])) * NW'($signed(di[k]))
                + NW'($signed(dq[k])) * NW'($signed(dq[k]));
    lead = PFLOOR;
    for (int b = 0; b < NW; b++)
      if (nrm[b] && b > PFLOOR) lead = b;
  end
  assign sh = LOG_L + ((mu_shift == '0) ? 1 : int'(mu_shift));

  // gradient, accumulation and tap step
  always_comb begin
    logic signed [GW-1:0]   pr_i, pr_q, g_i, g_q;
    logic signed [GW:0]     s_i, s_q;
    logic signed [ACCW:0]   d_i, d_q, t_i, t_q;
    for (int k = 0; k < NT; k++) begin
      pr_i = GW'($signed(di[k])) * GW'(e_i) + GW'($signed(dq[k])) * GW'(e_q);
      pr_q = GW'($signed(di[k])) * GW'(e_q) - GW'($signed(dq[k])) * GW'(e_i);
      g_i  = (pr_i <<< CFRAC) >>> lead;
      g_q  = (pr_q <<< CFRAC) >>> lead;
      s_i  = (GW+1)'($signed(ai[k])) + (GW+1)'(g_i);
      s_q  = (GW+1)'($signed(aq[k])) + (GW+1)'(g_q);
      an_i[k] = ACCW'(clip(64'(s_i), ACCW));
      an_q[k] = ACCW'(clip(64'(s_q), ACCW));
      d_i  = (ACCW+1)'($signed(an_i[k])) >>> sh;
      d_q  = (ACCW+1)'($signed(an_q[k])) >>> sh;
      t_i  = (ACCW+1)'($signed(ci[k])) - d_i;
      t_q  = (ACCW+1)'($signed(cq[k])) - d_q;
      cn_i[k] = CW'(clip(64'(t_i), CW));
      cn_q[k] = CW'(clip(64'(t_q), CW));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      di <= '0; dq <= '0; dpi <= '0; dpq <= '0; dp <= '0;
      vld_d <= 1'b0; out_vld <= 1'b0; out_i <= '0; out_q <= '0;
      mode_q <= 2'b10;
      for (int k = 0; k < NT; k++) ci[k] <= (k == CTR) ? ONE : '0;
      cq <= '0; ai <= '0; aq <= '0; cnt <= '0;
    end else begin
      vld_d  <= in_vld;
      mode_q <= {bypass, frame_lock};
      if (in_vld) begin
        di  <= {di[NT-2:0], in_i};
        dq  <= {dq[NT-2:0], in_q};
        dpi <= {dpi[CTR-1:0], ref_i};
        dpq <= {dpq[CTR-1:0], ref_q};
        dp  <= {dp[CTR-1:0], ref_vld};
      end
      out_vld <= vld_d;
      if (vld_d) begin
        out_i <= bypass ? $signed(di[CTR]) : y_i;
        out_q <= bypass ? $signed(dq[CTR]) : y_q;
      end
      if (mode_chg) begin
        ci <= tap_init; cq <= '0; ai <= '0; aq <= '0; cnt <= '0;
      end else if (qual) begin
        cnt <= cnt + 1'b1;
        if (blk_done) begin
          ci <= cn_i; cq <= cn_q; ai <= '0; aq <= '0;
        end else begin
          ai <= an_i; aq <= an_q;
        end
      end
    end
  end

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> ##1 out_vld); // R2
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_d |=> ($stable(out_i) && $stable(out_q))); // R2
  AST_BYPASS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !mode_chg) |=> ($stable(ci) && $stable(cq))); // R3
  AST_PILOT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_d && frame_lock && !bypass && !dp[CTR] && !mode_chg) |=>
      ($stable(ai) && $stable(aq) && $stable(cnt))); // R6
  AST_BLOCK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_done && !mode_chg) |=> ($stable(ci) && $stable(cq))); // R8
  AST_MODE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (ci == tap_init && cq == '0 && cnt == '0)); // R9
endmodule

// File: tb/blk_eq_adapt_tb_top.sv
`timescale 1ns/1ps
module blk_eq_adapt_tb_top;
  localparam int W = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_vld = 1'b0, frame_lock = 1'b0, bypass = 1'b1, ref_vld = 1'b0;
  logic signed [W-1:0] in_i = '0, in_q = '0, ref_i = '0, ref_q = '0;
  logic [3:0] mu_shift = 4'd2;
  logic out_vld;
  logic signed [W-1:0] out_i, out_q;

  int nchk = 0, nfail = 0;
  int h1i = 0, h1q = 0, h2i = 0, h2q = 0;
  int xq_i[$], xq_q[$];
  string xq_t[$];

  always #5 clk = ~clk;

  blk_eq_adapt dut_i (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .frame_lock(frame_lock), .bypass(bypass), .ref_vld(ref_vld), .ref_i(ref_i), .ref_q(ref_q),
    .mu_shift(mu_shift), .out_vld(out_vld), .out_i(out_i), .out_q(out_q));

  task automatic send(input int xi, input int xq, input bit pv, input int pi, input int pq,
                      input bit ovr, input int oi, input int oq, input string tag);
    @(negedge clk);
    in_vld = 1'b1; in_i = W'(xi); in_q = W'(xq);
    ref_vld = pv; ref_i = W'(pi); ref_q = W'(pq);
    xq_i.push_back(ovr ? oi : h2i);
    xq_q.push_back(ovr ? oq : h2q);
    xq_t.push_back(tag);
    h2i = h1i; h2q = h1q; h1i = xi; h1q = xq;
  endtask

  task automatic plain(input int xi, input int xq, input string tag);
    send(xi, xq, 1'b0, -2000, 777, 1'b0, 0, 0, tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_vld = 1'b0; ref_vld = 1'b0;
    end
  endtask

  task automatic set_mode(input bit byp, input bit lck, input int mu);
    idle(4);
    bypass = byp; frame_lock = lck; mu_shift = 4'(mu);
    idle(2);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      nchk++;
      if (xq_i.size() == 0) begin
        nfail++;
        $display("FAIL R2 unexpected output: actual %0d,%0d expected none", out_i, out_q);
      end else begin
        int ei, eq;
        string t;
        ei = xq_i.pop_front(); eq = xq_q.pop_front(); t = xq_t.pop_front();
        if (int'(out_i) != ei || int'(out_q) != eq) begin
          nfail++;
          $display("FAIL %s: actual %0d,%0d expected %0d,%0d", t, out_i, out_q, ei, eq);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    nchk++;
    if (out_vld !== 1'b0 || out_i !== '0 || out_q !== '0) begin
      nfail++;
      $display("FAIL R1 reset outputs: actual %0b %0d,%0d expected 0 0,0", out_vld, out_i, out_q);
    end

    // R3: bypass passthrough of arbitrary values
    plain(1536, 0, "R3"); plain(-700, 300, "R3"); plain(100, -2000, "R3");
    plain(2047, 2047, "R3"); plain(-2048, 5, "R3"); plain(0, 0, "R3");
    plain(900, -900, "R3"); plain(1024, 0, "R3"); plain(0, -1024, "R3");

    // R1/R4: blind mode, unit-modulus symbols leave taps at reset
    set_mode(1'b0, 1'b0, 2);
    plain(1024, 0, "R1"); plain(0, 1024, "R1");
    for (int k = 0; k < 10; k++)
      plain((k % 4 == 0) ? 1024 : (k % 4 == 2) ? -1024 : 0,
            (k % 4 == 1) ? 1024 : (k % 4 == 3) ? -1024 : 0, "R4");

    // R5/R8: blind adaptation on constant 1.5
    set_mode(1'b1, 1'b0, 2);
    for (int k = 0; k < 5; k++) plain(1536, 0, "R3");
    set_mode(1'b0, 1'b0, 2);
    for (int k = 0; k < 8; k++) plain(1536, 0, "R8");
    send(1536, 0, 1'b0, 0, 0, 1'b1, 1356, 0, "R5");

    // R6/R7/R8: pilot mode, non-reference symbols ignored, then adaptation
    set_mode(1'b1, 1'b0, 2);
    for (int k = 0; k < 5; k++) plain(512, 0, "R3");
    set_mode(1'b0, 1'b1, 2);
    plain(1536, -400, "R6"); plain(-1800, 1200, "R6"); plain(300, 300, "R6");
    plain(2000, -2000, "R6"); plain(-50, 1700, "R6"); plain(700, 0, "R6");
    plain(-1500, -1500, "R6"); plain(60, -90, "R6"); plain(1900, 10, "R6");
    plain(-1024, 512, "R6");
    for (int k = 0; k < 5; k++) plain(512, 0, "R6");
    for (int k = 0; k < 8; k++) send(512, 0, 1'b1, 1024, 0, 1'b0, 0, 0, "R8");
    plain(512, 0, "R8"); plain(512, 0, "R8");
    send(512, 0, 1'b0, 0, 0, 1'b1, 672, 0, "R7");

    // R10: same with step shift 3
    set_mode(1'b1, 1'b1, 3);
    for (int k = 0; k < 5; k++) plain(512, 0, "R3");
    set_mode(1'b0, 1'b1, 3);
    for (int k = 0; k < 8; k++) send(512, 0, 1'b1, 1024, 0, 1'b0, 0, 0, "R8");
    plain(512, 0, "R8"); plain(512, 0, "R8");
    send(512, 0, 1'b0, 0, 0, 1'b1, 592, 0, "R10");

    // R9: mode change after adaptation restores reset taps
    set_mode(1'b0, 1'b0, 3);
    for (int k = 0; k < 8; k++) plain((k % 2 == 0) ? 1024 : 0, (k % 2 == 1) ? -1024 : 0, "R9");

    idle(10);
    nchk++;
    if (xq_i.size() != 0) begin
      nfail++;
      $display("FAIL R2 missing outputs: actual %0d pending expected 0", xq_i.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule